// File: doc/BRIEF.md
# Control Endpoint Status Register with CPU Write Interlock

This block holds the status and mode byte of a bidirectional control endpoint. A CPU reaches it through single-cycle read and write strobes. A serial interface engine (SIE) updates it through its own strobes. The SIE reports which token kinds arrived (SETUP, IN, OUT), whether a handshake ACK closed the transaction, and the new four-bit response mode. Reset clears the whole byte, which leaves the endpoint in the disabled mode `0000`.

Status changes made by the SIE must not be lost to a stale CPU write. For that reason, an end-of-transaction update that carried an ACK or changed the mode sets a write lock. The lock stays until the CPU reads the register in a later cycle. The SETUP flag is forced high when the data phase of a SETUP transaction starts. The CPU cannot clear it until its next read. While that flag is high, the block gates off CPU writes into the endpoint's FIFO.

A parameter drops the interlock entirely. This gives a plain read/write status register for the non-control endpoints.

Top module: `ep0_status_interlock`

## Requirements
- R1: After reset the register reads `8'h00`, the lock output is low, and the FIFO write gate passes requests.
- R2: On `sie_update`, bit 6 (IN), bit 5 (OUT) and bit 4 (ACK) each become set when the matching input is high and otherwise keep their value. Bits 3:0 take `sie_mode`, and bit 7 (SETUP) is left alone. The new value is readable after the next clock edge.
- R3: `sie_update` sets the lock in the same cycle when `sie_ack` is high or `sie_mode` differs from the current bits 3:0. Otherwise the lock keeps its state.
- R4: While the lock is high, a CPU write changes no bit of the register.
- R5: A CPU read clears the lock at the next edge. A read in the same cycle as a locking update leaves the lock set.
- R6: `sie_setup_start` sets bit 7 and protects it. A CPU write cannot clear bit 7 until a CPU read in a later cycle removes the protection. After that, a write may clear it.
- R7: `fifo_wr_out` equals `fifo_wr_req` while bit 7 is low, and is low while bit 7 is high. The path is combinational.
- R8: A CPU write in the same cycle as `sie_update` is discarded, and only the SIE values are applied.
- R9: An unlocked CPU write loads bits 6:0 from `cpu_wdata`, and loads bit 7 when bit 7 is not protected.
- R10: With `LOCKING = 0`, the lock output stays low, bit 7 is never protected, and every CPU write that does not collide with an SIE update takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Current register value |
| sie_setup_start | input | 1 | Start of SETUP data phase |
| sie_update | input | 1 | End-of-transaction update strobe |
| sie_in | input | 1 | IN token seen |
| sie_out | input | 1 | OUT token seen |
| sie_ack | input | 1 | Transaction ended with ACK |
| sie_mode | input | 4 | New mode field |
| fifo_wr_req | input | 1 | CPU FIFO write request |
| fifo_wr_out | output | 1 | Gated FIFO write enable |
| lock_o | output | 1 | Write lock state |

## Verification
Every register result (field values, lock, SETUP protection) appears one clock edge after the strobe that causes it. The bench therefore drives inputs on the falling edge, waits for the rising edge, and compares 1 ns later against a bench model that is advanced by one step per edge. The FIFO gate has no register in its path. It is checked within the cycle the request is driven, before the edge, against the SETUP bit the model holds at that moment. A locked and a plain instance share the same stimulus, so each cycle also checks the `LOCKING = 0` variant.

// File: rtl/ep0_status_interlock.sv
module ep0_status_interlock #(
  parameter bit LOCKING = 1'b1,
  parameter int MODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [MODE_W+3:0] cpu_wdata,
  output logic [MODE_W+3:0] cpu_rdata,
  input  logic              sie_setup_start,
  input  logic              sie_update,
  input  logic              sie_in,
  input  logic              sie_out,
  input  logic              sie_ack,
  input  logic [MODE_W-1:0] sie_mode,
  input  logic              fifo_wr_req,
  output logic              fifo_wr_out,
  output logic              lock_o
);
  localparam int REG_W   = MODE_W + 4;
  localparam int B_SETUP = REG_W - 1;
  localparam int B_IN    = REG_W - 2;
  localparam int B_OUT   = REG_W - 3;
  localparam int B_ACK   = MODE_W;

  logic [REG_W-1:0] reg_q, reg_d;
  logic lock_q, prot_q;

  wire mode_chg  = sie_mode != reg_q[MODE_W-1:0];
  wire take_lock = sie_update & (sie_ack | mode_chg);
  wire wr_ok     = cpu_wr & ~sie_update & ~lock_q;

  always_comb begin
    reg_d = reg_q;
    if (sie_update) begin
      reg_d[B_IN]  = reg_q[B_IN]  | sie_in;
      reg_d[B_OUT] = reg_q[B_OUT] | sie_out;
      reg_d[B_ACK] = reg_q[B_ACK] | sie_ack;
      reg_d[MODE_W-1:0] = sie_mode;
    end else if (wr_ok) begin
      reg_d[B_SETUP-1:0] = cpu_wdata[B_SETUP-1:0];
      if (!prot_q) reg_d[B_SETUP] = cpu_wdata[B_SETUP];
    end
    if (sie_setup_start) reg_d[B_SETUP] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  generate
    if (LOCKING) begin : g_interlock
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lock_q <= 1'b0;
          prot_q <= 1'b0;
        end else begin
          if (take_lock)   lock_q <= 1'b1;
          else if (cpu_rd) lock_q <= 1'b0;
          if (sie_setup_start) prot_q <= 1'b1;
          else if (cpu_rd)     prot_q <= 1'b0;
        end
      end
    end else begin : g_plain
      assign lock_q = 1'b0;
      assign prot_q = 1'b0;
    end
  endgenerate

  assign cpu_rdata   = reg_q;
  assign lock_o      = lock_q;
  assign fifo_wr_out = fifo_wr_req & ~reg_q[B_SETUP];
endmodule

// File: rtl/ep0_status_interlock_chk.sv
module ep0_status_interlock_chk #(
  parameter bit LOCKING = 1'b1,
  parameter int MODE_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [MODE_W+3:0] cpu_rdata,
  input logic              sie_setup_start,
  input logic              sie_update,
  input logic              sie_ack,
  input logic              fifo_wr_out,
  input logic              lock_o
);
  localparam int TOP = MODE_W + 3;

  AST_ACK_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sie_update && sie_ack |=> cpu_rdata[MODE_W]); // R2
  AST_ACK_TAKES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    LOCKING && sie_update && sie_ack |=> lock_o); // R3
  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o && cpu_wr && !sie_update && !sie_setup_start |=> $stable(cpu_rdata)); // R4
  AST_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !sie_update |=> !lock_o); // R5
  AST_SETUP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup_start |=> cpu_rdata[TOP]); // R6
  AST_FIFO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[TOP] |-> !fifo_wr_out); // R7
  AST_PLAIN_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !LOCKING |-> !lock_o); // R10
endmodule

bind ep0_status_interlock ep0_status_interlock_chk #(.LOCKING(LOCKING), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
  .sie_setup_start(sie_setup_start), .sie_update(sie_update), .sie_ack(sie_ack),
  .fifo_wr_out(fifo_wr_out), .lock_o(lock_o)
);

// File: tb/ep0_status_interlock_test.sv
module ep0_status_interlock_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd = 0, wr = 0, ss = 0, upd = 0, s_in = 0, s_out = 0, s_ack = 0, fifo = 0;
  logic [7:0] wdata = 0;
  logic [3:0] mode = 0;
  logic [7:0] rdata, p_rdata;
  logic fifo_o, p_fifo_o, lock, p_lock;
  int checks = 0, errors = 0;

  logic [7:0] e_reg = 0, ep_reg = 0;
  logic e_lock = 0, e_prot = 0;

  always #2.5 clk = ~clk;

  ep0_status_interlock uut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(rd), .cpu_wr(wr), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .sie_setup_start(ss), .sie_update(upd), .sie_in(s_in), .sie_out(s_out), .sie_ack(s_ack),
    .sie_mode(mode), .fifo_wr_req(fifo), .fifo_wr_out(fifo_o), .lock_o(lock));

  ep0_status_interlock #(.LOCKING(1'b0)) uut_plain (
    .clk(clk), .rst_n(rst_n), .cpu_rd(rd), .cpu_wr(wr), .cpu_wdata(wdata), .cpu_rdata(p_rdata),
    .sie_setup_start(ss), .sie_update(upd), .sie_in(s_in), .sie_out(s_out), .sie_ack(s_ack),
    .sie_mode(mode), .fifo_wr_req(fifo), .fifo_wr_out(p_fifo_o), .lock_o(p_lock));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] next_reg(logic [7:0] r, logic lk, logic pr);
    logic [7:0] n = r;
    if (upd) begin
      n[6] = r[6] | s_in; n[5] = r[5] | s_out; n[4] = r[4] | s_ack; n[3:0] = mode;
    end else if (wr && !lk) begin
      n[6:0] = wdata[6:0];
      if (!pr) n[7] = wdata[7];
    end
    if (ss) n[7] = 1'b1;
    return n;
  endfunction

  task automatic cyc(string req);
    logic [7:0] n_reg, n_preg;
    logic n_lock, n_prot;
    #1;
    check("R7 fifo gate", {7'd0, fifo_o}, {7'd0, fifo & ~e_reg[7]});
    check("R10 plain fifo gate", {7'd0, p_fifo_o}, {7'd0, fifo & ~ep_reg[7]});
    n_reg  = next_reg(e_reg, e_lock, e_prot);
    n_preg = next_reg(ep_reg, 1'b0, 1'b0);
    n_lock = (upd && (s_ack || mode != e_reg[3:0])) ? 1'b1 : (rd ? 1'b0 : e_lock);
    n_prot = ss ? 1'b1 : (rd ? 1'b0 : e_prot);
    @(posedge clk); #1;
    e_reg = n_reg; ep_reg = n_preg; e_lock = n_lock; e_prot = n_prot;
    check(req, rdata, e_reg);
    check({req, " lock"}, {7'd0, lock}, {7'd0, e_lock});
    check("R10 plain reg", p_rdata, ep_reg);
    check("R10 plain lock", {7'd0, p_lock}, 8'd0);
    @(negedge clk);
  endtask

  task automatic drive(logic r, logic w, logic [7:0] d, logic s, logic u,
                       logic i, logic o, logic a, logic [3:0] m, logic f);
    rd = r; wr = w; wdata = d; ss = s; upd = u; s_in = i; s_out = o; s_ack = a; mode = m; fifo = f;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0,0,8'h00,0,0,0,0,0,4'h0,1); cyc("R1 reset state");
    drive(0,1,8'h0B,0,0,0,0,0,4'h0,0); cyc("R9 unlocked write");
    drive(0,0,8'h00,0,1,1,0,0,4'hB,0); cyc("R2 R3 update no lock");
    drive(0,0,8'h00,0,1,0,0,1,4'hA,0); cyc("R3 ack lock");
    drive(0,1,8'h00,0,0,0,0,0,4'h0,1); cyc("R4 locked write");
    drive(1,0,8'h00,0,1,0,0,0,4'h3,0); cyc("R5 read with update");
    drive(1,0,8'h00,0,0,0,0,0,4'h0,0); cyc("R5 read unlock");
    drive(0,1,8'h01,0,0,0,0,0,4'h0,0); cyc("R9 write after unlock");
    drive(0,0,8'h00,1,0,0,0,0,4'h0,1); cyc("R6 setup forced");
    drive(0,1,8'h00,0,0,0,0,0,4'h0,1); cyc("R6 protected bit7");
    drive(1,0,8'h00,0,0,0,0,0,4'h0,0); cyc("R6 read");
    drive(0,1,8'h00,0,0,0,0,0,4'h0,1); cyc("R6 clear after read");
    drive(0,1,8'h7F,0,1,0,1,0,4'h0,0); cyc("R8 collision");
    for (int k = 0; k < 400; k++) begin
      drive($urandom_range(3) == 0, $urandom_range(4) < 2, 8'($urandom),
            $urandom_range(19) == 0, $urandom_range(4) == 0, 1'($urandom), 1'($urandom),
            $urandom_range(2) == 0, ($urandom_range(1) == 0) ? e_reg[3:0] : 4'($urandom),
            1'($urandom));
      cyc("R2 R4 R9 random");
    end
    drive(0,0,8'h00,0,0,0,0,0,4'h0,0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule